// File: doc/BRIEF.md
# Write-Protect Register and Write Permission Guard

This block holds the write-protect control byte of a serial byte-addressed nonvolatile memory and decides, byte by byte, whether a data byte arriving from the serial front end may be acknowledged and written into the array. The front end hands over each decoded data byte with its address and a flag saying whether the access is a single direct access to the topmost address. Only such a direct access reaches the control byte. Every other access, including a page write or a sequential read that runs onto the top address, goes to the array byte stored there.

The control byte has two parts. Two volatile enable latches are cleared by the synchronous reset. The block-protect level and the hardware-lock enable are nonvolatile and are kept across that reset. The nonvolatile fields can only change after the enable latches have been set, one after the other. Writes to the array are refused inside the protected region, and the protect fields are frozen while the hardware write-protect pin and the lock enable are both high. A refused attempt raises a status flag.

Top module: `wpr_guard`

## Requirements
- R1: The live control byte `reg_q` is laid out as bit 7 = lock enable, bit 4 = protect level high, bit 3 = protect level low, bit 2 = second-stage enable, bit 1 = first-stage enable, with bits 6, 5 and 0 always 0. A cycle with `rst` high clears bits 2 and 1 and leaves bits 7, 4 and 3 unchanged.
- R2: While the first-stage enable is 0, an array data byte (any byte that is not a direct access to the top address) gets `ack_ok` = 0 and `arr_we` = 0. While it is 1, such a byte gets `ack_ok` = 1.
- R3: A direct write of 0x02 to the top address sets the first-stage enable. A direct write of 0x00 clears both enables.
- R4: A direct write of 0x06 or 0x07 sets the second-stage enable only if the first-stage enable is already set. Otherwise the register does not change.
- R5: With the second-stage enable set, a direct write of a byte of the form w00yz010 loads lock enable = w, protect level = yz, clears the second-stage enable and pulses `nv_update` in that cycle.
- R6: With the second-stage enable set, a direct write of a byte of the form w00yz110 changes neither the nonvolatile fields nor the enables.
- R7: Protect level 00 protects nothing, 01 protects addresses 0x600 to 0x7FF, 10 protects 0x400 to 0x7FF, and 11 protects the whole array. A write to a protected array byte gets `ack_ok` = 1, `arr_we` = 0 and `prot_flag` = 1.
- R8: While `wp_pin` and the lock enable are both 1, a load as in R5 is refused: the fields and the enables are unchanged, `prot_flag` = 1 and `nv_update` = 0. With `wp_pin` low the load is accepted.
- R9: Only a direct access at the top address selects the register. A non-direct write there is an array write and leaves the register unchanged. `rd_reg_sel` is 1 only for a direct read at the top address.
- R10: A direct register write is always acknowledged and never drives `arr_we`. A byte that matches none of the patterns above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, active high; clears only the volatile enables |
| wr_valid | input | 1 | A decoded data byte of a write is present |
| wr_addr | input | AW | Target byte address of the data byte |
| wr_data | input | 8 | Data byte |
| wr_direct | input | 1 | The byte is the single byte of a direct random write |
| rd_addr | input | AW | Address of the current read |
| rd_direct | input | 1 | The read is a direct random read |
| wp_pin | input | 1 | Hardware write-protect pin |
| ack_ok | output | 1 | Permission to acknowledge the data byte |
| arr_we | output | 1 | Write enable toward the array |
| prot_flag | output | 1 | A write attempt was refused by protection |
| nv_update | output | 1 | The nonvolatile fields are loaded at this clock edge |
| rd_reg_sel | output | 1 | The read returns the control byte instead of the array |
| reg_q | output | 8 | Live control byte |

## Verification
The bench targets the places where the protect sequence is easiest to get wrong. The byte 0x02 means "set first stage" when the second stage is clear, but "load zeros" when it is set. A design that checks the patterns in the wrong order would never be able to unprotect. Writing w00yz110 must hold the register still, and a design that loads the fields anyway would show new protect bits. The bench probes the edges of each protect range at 0x3FF/0x400 and 0x5FF/0x600, and a page write running onto the top address, where a shifted range or a missing direct check would write the wrong byte. Under the hardware lock it tries a load, and a design that ignores the pin would clear the lock. A soft reset must keep the protect level, and a design that resets it would lose protection.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic       wpen;
        logic [1:0] blk;
    } nv_bits_t;

    typedef struct packed {
        logic rwel;
        logic wel;
    } vol_bits_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CLEAR,
        CMD_SET_WEL,
        CMD_SET_RWEL,
        CMD_HOLD,
        CMD_LOAD
    } reg_cmd_e;

    function automatic logic [BYTE_W-1:0] pack_reg(nv_bits_t nv, vol_bits_t v);
        return {nv.wpen, 2'b00, nv.blk, v.rwel, v.wel, 1'b0};
    endfunction

    // Pattern order matters: with the second stage set, 0x02 is a load of zeros.
    function automatic reg_cmd_e decode_cmd(logic [BYTE_W-1:0] d, vol_bits_t v);
        logic fmt;
        fmt = (d[6:5] == 2'b00) && !d[0];
        if (d == 8'h00)                              return CMD_CLEAR;
        else if (v.rwel && fmt && d[2:1] == 2'b01)   return CMD_LOAD;
        else if (v.rwel && fmt && d[2:1] == 2'b11)   return CMD_HOLD;
        else if (d == 8'h02)                         return CMD_SET_WEL;
        else if (v.wel && d[7:1] == 7'b0000011)      return CMD_SET_RWEL;
        else                                         return CMD_NONE;
    endfunction

    function automatic logic in_block(logic [1:0] blk, logic [1:0] top2);
        case (blk)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wpr_state.sv
module wpr_state
    import wpr_pkg::*;
#(
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BLK  = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              lock,
    output nv_bits_t          nv,
    output vol_bits_t         vol,
    output logic              nv_upd,
    output logic              refused
);

    reg_cmd_e  cmd;
    nv_bits_t  nv_q = '{wpen: INIT_WPEN, blk: INIT_BLK};
    vol_bits_t vol_q;

    always_comb cmd = decode_cmd(cmd_data, vol_q);

    assign nv_upd  = cmd_valid && (cmd == CMD_LOAD) && !lock;
    assign refused = cmd_valid && (cmd == CMD_LOAD) && lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_q <= '0;
        end else if (cmd_valid) begin
            case (cmd)
                CMD_CLEAR:    vol_q <= '0;
                CMD_SET_WEL:  vol_q.wel <= 1'b1;
                CMD_SET_RWEL: vol_q.rwel <= 1'b1;
                CMD_LOAD:     if (!lock) vol_q.rwel <= 1'b0;
                default:      vol_q <= vol_q;
            endcase
        end
    end

    // Nonvolatile fields: no reset, they survive the soft reset.
    always_ff @(posedge clk) begin
        if (nv_upd) nv_q <= '{wpen: cmd_data[7], blk: cmd_data[4:3]};
    end

    assign nv  = nv_q;
    assign vol = vol_q;

    assert_rwel_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(vol_q.rwel) |-> $past(vol_q.wel));

    assert_nv_change_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (nv_q != $past(nv_q)) |-> ($past(vol_q.rwel) && !$past(lock)));

    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
        $past(lock) |-> (nv_q == $past(nv_q)));

    assert_soft_reset_R1: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (vol_q == '0));

endmodule

// File: rtl/wpr_gate.sv
module wpr_gate
    import wpr_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_direct,
    input  vol_bits_t     vol,
    input  nv_bits_t      nv,
    output logic          reg_target,
    output logic          ack_ok,
    output logic          arr_we,
    output logic          arr_prot
);

    localparam logic [AW-1:0] TOP_ADDR = '1;

    logic hit_block;

    always_comb begin
        reg_target = wr_valid && wr_direct && (wr_addr == TOP_ADDR);
        hit_block  = in_block(nv.blk, wr_addr[AW-1 -: 2]);
        ack_ok     = reg_target || (wr_valid && vol.wel);
        arr_we     = wr_valid && !reg_target && vol.wel && !hit_block;
        arr_prot   = wr_valid && !reg_target && vol.wel && hit_block;
    end

endmodule

// File: rtl/wpr_guard.sv
module wpr_guard
    import wpr_pkg::*;
#(
    parameter int         AW        = 11,
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BLK  = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_direct,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_direct,
    input  logic              wp_pin,
    output logic              ack_ok,
    output logic              arr_we,
    output logic              prot_flag,
    output logic              nv_update,
    output logic              rd_reg_sel,
    output logic [BYTE_W-1:0] reg_q
);

    localparam logic [AW-1:0] TOP_ADDR = '1;

    nv_bits_t  nv;
    vol_bits_t vol;
    logic      reg_target, arr_prot, refused, lock;

    assign lock = wp_pin && nv.wpen;

    wpr_gate #(.AW(AW)) u_gate (
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_direct (wr_direct),
        .vol       (vol),
        .nv        (nv),
        .reg_target(reg_target),
        .ack_ok    (ack_ok),
        .arr_we    (arr_we),
        .arr_prot  (arr_prot)
    );

    wpr_state #(.INIT_WPEN(INIT_WPEN), .INIT_BLK(INIT_BLK)) u_state (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(reg_target),
        .cmd_data (wr_data),
        .lock     (lock),
        .nv       (nv),
        .vol      (vol),
        .nv_upd   (nv_update),
        .refused  (refused)
    );

    assign prot_flag  = arr_prot || refused;
    assign rd_reg_sel = rd_direct && (rd_addr == TOP_ADDR);
    assign reg_q      = pack_reg(nv, vol);

    assert_no_wel_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> reg_q[1]);

    assert_full_block_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_q[4:3] == 2'b11) |-> !arr_we);

    assert_reg_never_arr_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_direct && wr_addr == TOP_ADDR) |-> !arr_we);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_q[6:5] == 2'b00) && !reg_q[0]);

endmodule

// File: tb/wpr_guard_bench.sv
module wpr_guard_bench;

    localparam int AW = 11;

    typedef struct {
        logic       ack, we, prot, nvu, sel;
        logic [7:0] regv;
        string      req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0, wr_direct = 1'b0, rd_direct = 1'b0, wp_pin = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          ack_ok, arr_we, prot_flag, nv_update, rd_reg_sel;
    logic [7:0]    reg_q;

    int errors = 0, checks = 0;
    item_t q[$];
    logic m_wel = 0, m_rwel = 0, m_wpen = 0;
    logic [1:0] m_bp = 0;

    always #2 clk = ~clk;

    wpr_guard #(.AW(AW)) u_wpr_guard (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_direct(wr_direct), .rd_addr(rd_addr), .rd_direct(rd_direct), .wp_pin(wp_pin),
        .ack_ok(ack_ok), .arr_we(arr_we), .prot_flag(prot_flag), .nv_update(nv_update),
        .rd_reg_sel(rd_reg_sel), .reg_q(reg_q)
    );

    function automatic logic [7:0] mreg();
        return {m_wpen, 2'b00, m_bp, m_rwel, m_wel, 1'b0};
    endfunction

    function automatic logic mprot(logic [AW-1:0] a);
        case (m_bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 11'h600;
            2'b10:   return a >= 11'h400;
            default: return 1'b1;
        endcase
    endfunction

    task automatic push(item_t it);
        it.regv = mreg();
        q.push_back(it);
    endtask

    task automatic idle(string req);
        item_t it;
        @(negedge clk);
        wr_valid = 0; rd_direct = 0;
        it = '{ack: 0, we: 0, prot: 0, nvu: 0, sel: 0, regv: 0, req: req};
        push(it);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic direct, string req);
        item_t it;
        @(negedge clk);
        wr_valid = 1; wr_addr = a; wr_data = d; wr_direct = direct; rd_direct = 0;
        it = '{ack: 0, we: 0, prot: 0, nvu: 0, sel: 0, regv: 0, req: req};
        if (direct && a == 11'h7FF) begin
            it.ack = 1;
            if (d == 8'h00) begin m_wel = 0; m_rwel = 0; end
            else if (m_rwel && d[6:5] == 0 && !d[0] && d[2:1] == 2'b01) begin
                if (wp_pin && m_wpen) it.prot = 1;
                else begin it.nvu = 1; m_wpen = d[7]; m_bp = d[4:3]; m_rwel = 0; end
            end
            else if (m_rwel && d[6:5] == 0 && !d[0] && d[2:1] == 2'b11) ;
            else if (d == 8'h02) m_wel = 1;
            else if (m_wel && d[7:1] == 7'b0000011) m_rwel = 1;
        end else if (m_wel) begin
            it.ack = 1;
            if (mprot(a)) it.prot = 1; else it.we = 1;
        end
        push(it);
    endtask

    task automatic rd(logic [AW-1:0] a, logic direct, string req);
        item_t it;
        @(negedge clk);
        wr_valid = 0; rd_addr = a; rd_direct = direct;
        it = '{ack: 0, we: 0, prot: 0, nvu: 0, sel: direct && a == 11'h7FF, regv: 0, req: req};
        push(it);
    endtask

    task automatic soft_reset(string req);
        item_t it;
        @(negedge clk);
        wr_valid = 0; rd_direct = 0; rst = 1;
        m_wel = 0; m_rwel = 0;
        it = '{ack: 0, we: 0, prot: 0, nvu: 0, sel: 0, regv: 0, req: req};
        push(it);
        @(negedge clk);
        rst = 0;
        it.req = req;
        push(it);
    endtask

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: comb outputs at negedge+1, register value one cycle later.
    initial begin
        item_t pend;
        logic  have = 0;
        forever begin
            @(negedge clk);
            #1;
            if (have) chk(pend.req, "reg_q", reg_q, pend.regv);
            have = 0;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.req, "ack_ok", {7'b0, ack_ok}, {7'b0, it.ack});
                chk(it.req, "arr_we", {7'b0, arr_we}, {7'b0, it.we});
                chk(it.req, "prot_flag", {7'b0, prot_flag}, {7'b0, it.prot});
                chk(it.req, "nv_update", {7'b0, nv_update}, {7'b0, it.nvu});
                chk(it.req, "rd_reg_sel", {7'b0, rd_reg_sel}, {7'b0, it.sel});
                pend = it;
                have = 1;
            end
        end
    end

    initial begin
        #4000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        idle("R1");                     // reset state 0x00
        wr(11'h100, 8'hAA, 0, "R2");    // WEL clear: no ack
        wr(11'h7FF, 8'h55, 1, "R10");   // unknown pattern ignored, acked
        wr(11'h7FF, 8'h06, 1, "R4");    // RWEL without WEL ignored
        wr(11'h7FF, 8'h02, 1, "R3");    // set WEL
        wr(11'h100, 8'hAA, 0, "R2");    // now acked and written
        wr(11'h7FF, 8'h06, 1, "R4");    // set RWEL
        wr(11'h7FF, 8'h96, 1, "R6");    // hold pattern
        wr(11'h7FF, 8'h0A, 1, "R5");    // load BP=01
        wr(11'h5FF, 8'h11, 0, "R7");
        wr(11'h600, 8'h11, 0, "R7");
        wr(11'h7FF, 8'h11, 0, "R9");    // page write onto top: array, protected
        wr(11'h7FF, 8'h06, 1, "R4");
        wr(11'h7FF, 8'h12, 1, "R5");    // load BP=10
        wr(11'h3FF, 8'h22, 0, "R7");
        wr(11'h400, 8'h22, 0, "R7");
        wr(11'h7FF, 8'h06, 1, "R4");
        wr(11'h7FF, 8'h9A, 1, "R5");    // WPEN=1, BP=11
        wr(11'h000, 8'h33, 0, "R7");
        @(negedge clk); wp_pin = 1;
        wr(11'h7FF, 8'h06, 1, "R8");
        wr(11'h7FF, 8'h02, 1, "R8");    // load refused under lock
        idle("R8");
        @(negedge clk); wp_pin = 0;
        wr(11'h7FF, 8'h02, 1, "R8");    // load of zeros accepted
        wr(11'h000, 8'h44, 0, "R7");    // BP=00: writable
        wr(11'h7FF, 8'h44, 0, "R9");    // non-direct top: array write
        wr(11'h7FF, 8'h00, 1, "R3");    // clear WEL
        wr(11'h7FF, 8'h02, 1, "R3");
        wr(11'h7FF, 8'h07, 1, "R4");
        wr(11'h7FF, 8'h0A, 1, "R5");
        wr(11'h7FF, 8'h06, 1, "R4");
        soft_reset("R1");               // BP kept, enables cleared
        rd(11'h7FF, 1, "R9");
        rd(11'h7FF, 0, "R9");
        rd(11'h7FE, 1, "R9");
        idle("R1");
        wait (q.size() == 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule